// File: doc/BRIEF.md
# ADC Conversion Sequencer with Selection Latching

This block sequences a successive-approximation converter in the converter's own clock domain. Software places a channel number and a reference choice in a holding register. The block decides when that register is copied into the live selection, which drives the analog multiplexer and the reference switch. A start strobe launches a conversion. The block counts the conversion cycles, emits a sample-and-hold strobe at the sampling point, and raises a sticky completion flag. An optional free-running setting restarts the next conversion as soon as one completes.

While the block is idle, the live selection tracks the holding register with one clock of latency. When a conversion begins, the live selection is frozen so that the sampled input is stable for its whole sampling window. The freeze is released in the final cycle of the conversion, which is the same cycle that sets the flag. In free-running mode this means a selection written just after a completion only takes effect one conversion later.

The first conversion after reset, or after the enable is raised again, is a long conversion that also settles the analog front end. Every later conversion is a short one. Dropping the enable aborts any conversion in progress.

Top module: `adcseq_top`

## Requirements
- R1: A holding write with a reference code of 2'b00 (external pin), 2'b01 (analog supply) or 2'b11 (internal 2.56 V) loads both the channel and the reference into the holding register. A write with the reserved code 2'b10 is ignored entirely, and the live outputs keep their previous value.
- R2: While no conversion is in progress, every rising clock copies the holding register into the live selection, so the live outputs follow a write one cycle later.
- R3: A `start_wr` sampled high on a rising edge while `en` is high and the block is idle begins a conversion at that edge, and `busy` reads 1 from the next cycle. A `start_wr` sampled while `en` is low, or while a conversion runs, has no effect.
- R4: During conversion cycles 1 to N-1 the live selection holds the value it had at the start edge. At the end of the final cycle N, it copies the holding register again.
- R5: A normal conversion lasts 13 cycles: `busy` stays high for 13 cycles after the start edge.
- R6: The first conversion after reset, or after `en` rises, is extended to 25 cycles, and `conv_ext` is high for its duration.
- R7: `sh_strobe` rises on the falling clock edge in the middle of conversion cycle 2 for a normal conversion, or cycle 14 for an extended one. It stays high until the next falling edge and is never high outside a conversion.
- R8: `done_flag` is set at the end of the final conversion cycle and stays set until `flag_clr` is applied. When a set and a clear occur together, the set wins.
- R9: With `free_run` high, the next normal conversion begins immediately after the final cycle, without a gap in `busy`. A selection written during its first cycle only reaches the live outputs at the end of that conversion.
- R10: With `free_run` low, `busy` returns to 0 after the final cycle.
- R11: When `en` is sampled low, any conversion is aborted, `busy` is 0 in the next cycle and no flag is set. The live selection tracks the holding register again, and the next conversion is extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | converter clock |
| rst | input | 1 | synchronous active-high reset |
| en | input | 1 | converter enable |
| free_run | input | 1 | restart automatically on completion |
| start_wr | input | 1 | start strobe (write of the start bit) |
| flag_clr | input | 1 | clear the completion flag |
| hold_wr | input | 1 | write strobe for the holding register |
| hold_chan | input | CH_W | channel number to hold |
| hold_ref | input | 2 | reference code to hold |
| busy | output | 1 | start bit readback, high while converting |
| conv_ext | output | 1 | the running conversion is an extended one |
| sh_strobe | output | 1 | sample-and-hold strobe, launched on a falling edge |
| done_flag | output | 1 | sticky completion flag |
| live_chan | output | CH_W | channel driving the analog multiplexer |
| live_ref | output | 2 | reference driving the reference switch |

## Verification
The bench builds the block with its default parameters: 4-bit channels, 13-cycle normal and 25-cycle extended conversions, and sampling cycles 2 and 14. The full timing is therefore exercised exactly as specified, including the long first conversion after enable. These lengths are short enough that several complete free-running chains, an abort in mid-conversion and a re-enabled extended conversion all fit in one run. At these values, a selection written during cycle 1 of a chained conversion, and a clear that collides with a completion, can both be placed on exact cycles.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [1:0] {
    REF_PIN      = 2'b00,
    REF_SUPPLY   = 2'b01,
    REF_RSVD     = 2'b10,
    REF_INTERNAL = 2'b11
  } ref_sel_e;

  function automatic logic ref_is_legal(input logic [1:0] code);
    return code != REF_RSVD;
  endfunction

endpackage

// File: rtl/adcseq_sel_latch.sv
module adcseq_sel_latch
  import adcseq_pkg::*;
#(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold_wr,
  input  logic [CH_W-1:0] hold_chan,
  input  logic [1:0]      hold_ref,
  input  logic            copy_en,
  output logic [CH_W-1:0] held_chan,
  output logic [CH_W-1:0] live_chan,
  output logic [1:0]      live_ref
);

  logic [1:0] held_ref;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_chan <= '0;
      held_ref  <= REF_PIN;
    end else if (hold_wr && ref_is_legal(hold_ref)) begin
      held_chan <= hold_chan;
      held_ref  <= hold_ref;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_chan <= '0;
      live_ref  <= REF_PIN;
    end else if (copy_en) begin
      live_chan <= held_chan;
      live_ref  <= held_ref;
    end
  end

endmodule

// File: rtl/adcseq_timer.sv
module adcseq_timer #(
  parameter int N_NORM = 13,
  parameter int N_EXT  = 25,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start_wr,
  input  logic             free_run,
  output logic             busy,
  output logic             ext,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);

  localparam logic [CNT_W-1:0] LEN_N = CNT_W'(N_NORM);
  localparam logic [CNT_W-1:0] LEN_E = CNT_W'(N_EXT);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic first_q;
  logic [CNT_W-1:0] len_now;

  assign len_now = ext ? LEN_E : LEN_N;
  assign last    = busy && (cnt == len_now);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      busy    <= 1'b0;
      ext     <= 1'b0;
      cnt     <= '0;
      first_q <= 1'b1;
    end else if (!busy) begin
      if (start_wr) begin
        busy    <= 1'b1;
        cnt     <= ONE;
        ext     <= first_q;
        first_q <= 1'b0;
      end
    end else if (last) begin
      ext <= 1'b0;
      if (free_run) begin
        cnt <= ONE;
      end else begin
        busy <= 1'b0;
        cnt  <= '0;
      end
    end else begin
      cnt <= cnt + ONE;
    end
  end

endmodule

// File: rtl/adcseq_sh_gen.sv
module adcseq_sh_gen #(
  parameter int SH_NORM = 2,
  parameter int SH_EXT  = 14,
  parameter int CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic             ext,
  input  logic [CNT_W-1:0] cnt,
  output logic             sh_strobe
);

  localparam logic [CNT_W-1:0] AT_N = CNT_W'(SH_NORM);
  localparam logic [CNT_W-1:0] AT_E = CNT_W'(SH_EXT);

  logic [CNT_W-1:0] at_now;
  assign at_now = ext ? AT_E : AT_N;

  // Launched mid-cycle to place the sampling point half a cycle in.
  always_ff @(negedge clk) begin
    if (rst) sh_strobe <= 1'b0;
    else     sh_strobe <= busy && (cnt == at_now);
  end

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top #(
  parameter int CH_W    = 4,
  parameter int N_NORM  = 13,
  parameter int N_EXT   = 25,
  parameter int SH_NORM = 2,
  parameter int SH_EXT  = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            free_run,
  input  logic            start_wr,
  input  logic            flag_clr,
  input  logic            hold_wr,
  input  logic [CH_W-1:0] hold_chan,
  input  logic [1:0]      hold_ref,
  output logic            busy,
  output logic            conv_ext,
  output logic            sh_strobe,
  output logic            done_flag,
  output logic [CH_W-1:0] live_chan,
  output logic [1:0]      live_ref
);

  localparam int LONGEST = (N_EXT > N_NORM) ? N_EXT : N_NORM;
  localparam int CNT_W   = $clog2(LONGEST + 1);

  logic [CNT_W-1:0] cyc_cnt;
  logic             last_cyc;
  logic [CH_W-1:0]  hold_chan_q;

  adcseq_timer #(.N_NORM(N_NORM), .N_EXT(N_EXT), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .en(en), .start_wr(start_wr), .free_run(free_run),
    .busy(busy), .ext(conv_ext), .cnt(cyc_cnt), .last(last_cyc)
  );

  adcseq_sh_gen #(.SH_NORM(SH_NORM), .SH_EXT(SH_EXT), .CNT_W(CNT_W)) u_sh (
    .clk(clk), .rst(rst), .busy(busy), .ext(conv_ext), .cnt(cyc_cnt),
    .sh_strobe(sh_strobe)
  );

  adcseq_sel_latch #(.CH_W(CH_W)) u_sel (
    .clk(clk), .rst(rst), .hold_wr(hold_wr), .hold_chan(hold_chan),
    .hold_ref(hold_ref), .copy_en(!busy || last_cyc),
    .held_chan(hold_chan_q), .live_chan(live_chan), .live_ref(live_ref)
  );

  always_ff @(posedge clk) begin
    if (rst)                  done_flag <= 1'b0;
    else if (last_cyc && en)  done_flag <= 1'b1;
    else if (flag_clr)        done_flag <= 1'b0;
  end

endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk #(
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            en,
  input logic            start_wr,
  input logic            busy,
  input logic            conv_ext,
  input logic            sh_strobe,
  input logic            done_flag,
  input logic            last_cyc,
  input logic [CH_W-1:0] hold_chan_q,
  input logic [CH_W-1:0] live_chan,
  input logic [1:0]      live_ref
);

  AST_IDLE_TRACK: assert property (@(posedge clk) disable iff (rst)
    !busy |=> live_chan == $past(hold_chan_q)); // R2

  AST_START_TAKES: assert property (@(posedge clk) disable iff (rst)
    en && !busy && start_wr |=> busy); // R3

  AST_LIVE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy && !last_cyc |=> $stable(live_chan) && $stable(live_ref)); // R4

  AST_EXT_IN_CONV: assert property (@(posedge clk) disable iff (rst)
    conv_ext |-> busy); // R6

  AST_SH_IN_CONV: assert property (@(posedge clk) disable iff (rst)
    sh_strobe |-> busy); // R7

  AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    last_cyc && en |=> done_flag); // R8

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> !busy && !done_flag || !busy && $stable(done_flag)); // R11

endmodule

bind adcseq_top adcseq_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .start_wr(start_wr), .busy(busy),
  .conv_ext(conv_ext), .sh_strobe(sh_strobe), .done_flag(done_flag),
  .last_cyc(last_cyc), .hold_chan_q(hold_chan_q), .live_chan(live_chan),
  .live_ref(live_ref)
);

// File: tb/adcseq_top_test.sv
module adcseq_top_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, free_run = 1'b0, start_wr = 1'b0, flag_clr = 1'b0, hold_wr = 1'b0;
  logic [3:0] hold_chan = '0;
  logic [1:0] hold_ref = '0;
  logic busy, conv_ext, sh_strobe, done_flag;
  logic [3:0] live_chan;
  logic [1:0] live_ref;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  adcseq_top uut (
    .clk(clk), .rst(rst), .en(en), .free_run(free_run), .start_wr(start_wr),
    .flag_clr(flag_clr), .hold_wr(hold_wr), .hold_chan(hold_chan), .hold_ref(hold_ref),
    .busy(busy), .conv_ext(conv_ext), .sh_strobe(sh_strobe), .done_flag(done_flag),
    .live_chan(live_chan), .live_ref(live_ref)
  );

  task automatic chk(input string tag, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced once per cycle just before the rising edge
  bit m_valid = 0, m_busy, m_ext, m_first, m_flag;
  int m_k, m_len;
  int m_hc, m_hr, m_lc, m_lr;

  initial forever begin
    @(negedge clk); #3;
    if (m_valid && !rst) begin
      chk("R5", busy, m_busy, "model busy");
      chk("R6", conv_ext, m_ext, "model conv_ext");
      chk("R8", done_flag, m_flag, "model flag");
      chk("R4", live_chan, m_lc, "model live_chan");
      chk("R1", live_ref, m_lr, "model live_ref");
      chk("R7", sh_strobe, (m_busy && m_k == (m_ext ? 14 : 2)) ? 1 : 0, "model sh");
    end
    if (rst) begin
      m_valid = 1; m_busy = 0; m_ext = 0; m_first = 1; m_flag = 0; m_k = 0; m_len = 13;
      m_hc = 0; m_hr = 0; m_lc = 0; m_lr = 0;
    end else begin
      bit fin;
      fin = m_busy && m_k == m_len;
      if (fin && en) m_flag = 1; else if (flag_clr) m_flag = 0;
      if (!m_busy || fin) begin m_lc = m_hc; m_lr = m_hr; end
      if (hold_wr && hold_ref != 2'b10) begin m_hc = hold_chan; m_hr = hold_ref; end
      if (!en) begin
        m_busy = 0; m_k = 0; m_ext = 0; m_first = 1;
      end else if (!m_busy) begin
        if (start_wr) begin
          m_busy = 1; m_k = 1; m_ext = m_first; m_len = m_first ? 25 : 13; m_first = 0;
        end
      end else if (fin) begin
        m_ext = 0; m_len = 13;
        if (free_run) m_k = 1; else begin m_busy = 0; m_k = 0; end
      end else m_k++;
    end
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 100) begin n++; step(); end
  endtask

  task automatic sh_pos(output int p);
    p = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #1; p++;
      if (sh_strobe) break;
    end
  endtask

  task automatic write_hold(input int c, input int r);
    hold_wr = 1; hold_chan = 4'(c); hold_ref = 2'(r); step(); hold_wr = 0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R3 watchdog expired act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    int n, p, guard;
    repeat (3) step();
    rst = 0;
    chk("R5", busy, 0, "reset busy");
    chk("R8", done_flag, 0, "reset flag");
    chk("R7", sh_strobe, 0, "reset sh");
    en = 1;
    // R2: live follows a write one cycle later
    write_hold(5, 1);
    chk("R2", live_chan, 0, "live one cycle after write");
    step();
    chk("R2", live_chan, 5, "live two cycles after write");
    chk("R1", live_ref, 1, "legal ref supply");
    // R1: reserved reference code drops the whole write
    write_hold(9, 2);
    step(); step();
    chk("R1", live_chan, 5, "reserved write chan");
    chk("R1", live_ref, 1, "reserved write ref");
    write_hold(5, 3);
    step();
    chk("R1", live_ref, 3, "legal ref internal");
    // R6: first conversion after enable is extended
    start_wr = 1; step(); start_wr = 0;
    chk("R3", busy, 1, "busy after start");
    chk("R6", conv_ext, 1, "extended marker");
    fork
      count_busy(n);
      sh_pos(p);
      begin
        repeat (4) step();
        write_hold(3, 0);
        repeat (4) step();
        chk("R4", live_chan, 5, "frozen mid conversion");
      end
    join
    chk("R6", n, 25, "extended length");
    chk("R7", p, 14, "extended sample point");
    chk("R8", done_flag, 1, "flag after extended");
    chk("R4", live_chan, 3, "copied at final cycle");
    chk("R10", busy, 0, "single mode idle");
    // R8 clear, then collision set-vs-clear, R5 normal length, R3 start while busy
    flag_clr = 1; step();
    chk("R8", done_flag, 0, "flag cleared");
    start_wr = 1; step(); start_wr = 0;
    chk("R6", conv_ext, 0, "second is normal");
    fork
      count_busy(n);
      sh_pos(p);
      begin repeat (4) step(); start_wr = 1; step(); start_wr = 0; end
    join
    chk("R5", n, 13, "normal length with extra start");
    chk("R7", p, 2, "normal sample point");
    chk("R8", done_flag, 1, "set wins over clear");
    flag_clr = 0;
    // R9: free running chain with lag
    flag_clr = 1; step(); flag_clr = 0;
    free_run = 1;
    start_wr = 1; step(); start_wr = 0;
    guard = 0;
    while (!done_flag && guard < 100) begin step(); guard++; end
    chk("R9", busy, 1, "no gap after completion");
    chk("R9", live_chan, 3, "chained conversion uses old select");
    write_hold(7, 1);
    flag_clr = 1; step(); flag_clr = 0;
    repeat (5) step();
    chk("R9", live_chan, 3, "new select not yet live");
    guard = 0;
    while (!done_flag && guard < 100) begin step(); guard++; end
    chk("R9", live_chan, 7, "new select live after next completion");
    chk("R9", busy, 1, "third conversion running");
    free_run = 0;
    count_busy(n);
    chk("R10", n, 13, "last chained length");
    chk("R10", busy, 0, "stopped after free run cleared");
    // R11: abort
    flag_clr = 1; step(); flag_clr = 0;
    start_wr = 1; step(); start_wr = 0;
    repeat (4) step();
    en = 0; step();
    chk("R11", busy, 0, "abort busy");
    write_hold(2, 0);
    step();
    chk("R11", live_chan, 2, "tracking after abort");
    repeat (20) step();
    chk("R11", done_flag, 0, "no flag on abort");
    start_wr = 1; step(); start_wr = 0;
    chk("R3", busy, 0, "start ignored while disabled");
    en = 1; step();
    start_wr = 1; step(); start_wr = 0;
    chk("R11", conv_ext, 1, "extended after re-enable");
    count_busy(n);
    chk("R11", n, 25, "re-enabled length");
    step();
    summary();
    $finish;
  end

endmodule